// File: doc/BRIEF.md
# Triggered Accumulating Acquisition Sequencer

This block runs repeated, trigger-synchronised capture sweeps against an external 12-bit analog-to-digital converter and integrates the results in an on-chip record memory. A start command first zeroes every record word. Each sweep then raises a trigger toward an external signal generator and waits for the generator's acknowledge before it issues any conversion. Every converted sample is added to the record word at the current sample index, so after the programmed number of sweeps each word holds the sum of that record position over all sweeps.

The converter is paced by a conversion clock whose falling edge starts a conversion. The sequencer waits for the rising edge of the converter's end-of-conversion flag, takes the result, reads the addressed word, and writes back the sum. A two-bit channel select, latched at start, chooses one of four analog inputs for the whole run. A programmable timeout on the acknowledge trigger aborts a run with an error flag. Every memory write appears on an observation port, so a host or bench can follow the record as it grows.

Top module: `acq_integrator`

## Requirements
- R1: A start_i pulse while idle writes zero to every record word, addresses 0 up to DEPTH-1 in ascending order on consecutive cycles, before the first sweep. A start_i pulse at any other time has no effect.
- R2: At the start of each sweep trig_out_o goes high. No falling edge of conv_clk_o occurs until a rising edge of trig_in_i has been seen. trig_out_o returns low once that edge has been seen.
- R3: conv_clk_o is high when no conversion is being started. Each conversion starts with a falling edge that keeps conv_clk_o low for exactly CONV_LOW cycles. Successive falling edges are at least CONV_PERIOD cycles apart.
- R4: On the rising edge of adc_eoc_i, the value on adc_data_i is taken as the sample. The block then writes, at the current index, the previous word plus that sample (zero-extended).
- R5: The index starts at 0 in each sweep and advances by one per sample. After DEPTH samples a sweep ends and the next one begins with a new trigger. A complete run makes DEPTH*(1+NUM_SWEEPS) writes.
- R6: After NUM_SWEEPS sweeps, done_o goes high and stays high until the next start. While done_o is high there are no writes, trig_out_o is low and conv_clk_o is high.
- R7: chan_sel_o takes the value of chan_i at the accepted start and holds it for the whole run.
- R8: If timeout_i is non-zero and no trigger-in edge arrives within timeout_i cycles of trig_out_o rising, the block sets err_o and drops trig_out_o. It then returns to idle with no further writes or conversions. timeout_i of zero waits without limit. An accepted start clears err_o.
- R9: Record words are DATA_W bits wide, and NUM_SWEEPS*(2^SAMPLE_W-1) fits in them, so an accumulated word never wraps.
- R10: After reset, trig_out_o, done_o, err_o and mem_we_o are low and conv_clk_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear-and-acquire command, honoured only when idle |
| chan_i | input | 2 | Analog input to select for the run |
| timeout_i | input | TMO_W | Acknowledge timeout in cycles, 0 = none |
| trig_out_o | output | 1 | Trigger request to the signal generator |
| trig_in_i | input | 1 | Acknowledge trigger from the signal generator |
| conv_clk_o | output | 1 | Converter start clock, falling edge starts a conversion |
| chan_sel_o | output | 2 | Converter input multiplexer select |
| adc_data_i | input | SAMPLE_W | Converter result |
| adc_eoc_i | input | 1 | Converter end-of-conversion flag |
| mem_we_o | output | 1 | Record memory write strobe |
| mem_addr_o | output | log2(DEPTH) | Record memory write address |
| mem_wdata_o | output | DATA_W | Record memory write data |
| done_o | output | 1 | All sweeps finished |
| err_o | output | 1 | Run aborted on acknowledge timeout |

## Verification
The bench builds the block with DEPTH=8, NUM_SWEEPS=3, CONV_PERIOD=10 and CONV_LOW=2. With these values a full run of 32 writes takes a few hundred cycles, so several whole runs fit in one bench, including back-to-back runs in which the clear phase must remove an earlier, larger record. With only eight words, the index wrap and the sweep boundary recur often. Each sweep boundary exercises the trigger handshake again, and an all-ones run checks the accumulation at full sample scale.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CLEAR,
    S_TRIG,
    S_ARM,
    S_LOW,
    S_WAIT,
    S_READ,
    S_WRITE
  } acq_state_e;
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q[0] <= 1'b0;
    else         sr_q[0] <= d_i;
  end

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[gi] <= 1'b0;
      else         sr_q[gi] <= sr_q[gi-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sr_q[STAGES-1];
  end

  assign rise_o = sr_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/acq_pacer.sv
module acq_pacer #(
  parameter int PERIOD = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic ready_o
);
  localparam int PACE_W = $clog2(PERIOD + 1);

  logic [PACE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (fire_i)          cnt_q <= PACE_W'(PERIOD - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/acq_ram.sv
module acq_ram #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/acq_integrator.sv
module acq_integrator
  import acq_pkg::*;
#(
  parameter int DEPTH       = 2048,
  parameter int SAMPLE_W    = 12,
  parameter int DATA_W      = 16,
  parameter int NUM_SWEEPS  = 13,
  parameter int CONV_PERIOD = 100,
  parameter int CONV_LOW    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TMO_W       = 24,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          chan_i,
  input  logic [TMO_W-1:0]    timeout_i,
  output logic                trig_out_o,
  input  logic                trig_in_i,
  output logic                conv_clk_o,
  output logic [1:0]          chan_sel_o,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  input  logic                adc_eoc_i,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                done_o,
  output logic                err_o
);
  localparam int SWP_W = $clog2(NUM_SWEEPS + 1);
  localparam int LOW_W = $clog2(CONV_LOW + 1);
  localparam logic [ADDR_W-1:0] LAST_IDX   = ADDR_W'(DEPTH - 1);
  localparam logic [SWP_W-1:0]  LAST_SWEEP = SWP_W'(NUM_SWEEPS - 1);

  acq_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   idx_q, idx_d;
  logic [SWP_W-1:0]    sweep_q, sweep_d;
  logic [TMO_W-1:0]    tmo_q, tmo_d;
  logic [LOW_W-1:0]    low_q, low_d;
  logic [SAMPLE_W-1:0] sample_q, sample_d;
  logic [1:0]          chan_q, chan_d;
  logic                done_q, done_d;
  logic                err_q, err_d;
  logic                trig_q, conv_clk_q;
  logic                fire, pace_ready, trig_rise, eoc_rise;
  logic [DATA_W-1:0]   rd_data;
  logic                acc_wr;

  acq_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk_i, .rst_ni, .d_i(trig_in_i), .rise_o(trig_rise)
  );

  acq_sync #(.STAGES(SYNC_STAGES)) u_eoc_sync (
    .clk_i, .rst_ni, .d_i(adc_eoc_i), .rise_o(eoc_rise)
  );

  acq_pacer #(.PERIOD(CONV_PERIOD)) u_pacer (
    .clk_i, .rst_ni, .fire_i(fire), .ready_o(pace_ready)
  );

  acq_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk_i,
    .we_i   (mem_we_o),
    .waddr_i(mem_addr_o),
    .wdata_i(mem_wdata_o),
    .raddr_i(idx_q),
    .rdata_o(rd_data)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    sweep_d  = sweep_q;
    tmo_d    = tmo_q;
    low_d    = low_q;
    sample_d = sample_q;
    chan_d   = chan_q;
    done_d   = done_q;
    err_d    = err_q;
    fire     = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_CLEAR;
          idx_d   = '0;
          sweep_d = '0;
          done_d  = 1'b0;
          err_d   = 1'b0;
          chan_d  = chan_i;
        end
      end
      S_CLEAR: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          idx_d   = '0;
          tmo_d   = '0;
          state_d = S_TRIG;
        end
      end
      S_TRIG: begin
        tmo_d = tmo_q + 1'b1;
        if (trig_rise) begin
          state_d = S_ARM;
        end else if (timeout_i != '0 && tmo_q == timeout_i - TMO_W'(1)) begin
          err_d   = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_ARM: begin
        if (pace_ready) begin
          fire    = 1'b1;
          low_d   = '0;
          state_d = S_LOW;
        end
      end
      S_LOW: begin
        low_d = low_q + 1'b1;
        if (low_q == LOW_W'(CONV_LOW - 1)) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (eoc_rise) begin
          sample_d = adc_data_i;
          state_d  = S_READ;
        end
      end
      S_READ: state_d = S_WRITE;
      S_WRITE: begin
        if (idx_q == LAST_IDX) begin
          idx_d = '0;
          if (sweep_q == LAST_SWEEP) begin
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            sweep_d = sweep_q + 1'b1;
            tmo_d   = '0;
            state_d = S_TRIG;
          end
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = S_ARM;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      sweep_q    <= '0;
      tmo_q      <= '0;
      low_q      <= '0;
      sample_q   <= '0;
      chan_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      trig_q     <= 1'b0;
      conv_clk_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      sweep_q    <= sweep_d;
      tmo_q      <= tmo_d;
      low_q      <= low_d;
      sample_q   <= sample_d;
      chan_q     <= chan_d;
      done_q     <= done_d;
      err_q      <= err_d;
      trig_q     <= (state_d == S_TRIG);
      conv_clk_q <= (state_d != S_LOW);
    end
  end

  assign acc_wr      = (state_q == S_WRITE);
  assign mem_we_o    = acc_wr || (state_q == S_CLEAR);
  assign mem_addr_o  = idx_q;
  assign mem_wdata_o = acc_wr ? rd_data + DATA_W'(sample_q) : '0;

  assign trig_out_o = trig_q;
  assign conv_clk_o = conv_clk_q;
  assign chan_sel_o = chan_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/acq_integrator_chk.sv
module acq_integrator_chk #(
  parameter int SAMPLE_W    = 12,
  parameter int DATA_W      = 16,
  parameter int NUM_SWEEPS  = 13,
  parameter int CONV_PERIOD = 100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_out_o,
  input logic              conv_clk_o,
  input logic [1:0]        chan_sel_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              done_o,
  input logic              err_o,
  input logic              acc_wr,
  input logic [DATA_W-1:0] rd_data
);
  localparam int GAP_W = $clog2(CONV_PERIOD + 2);

  logic             prev_clk_q, seen_fall_q, fell;
  logic [GAP_W-1:0] gap_q;

  assign fell = prev_clk_q && !conv_clk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_clk_q  <= 1'b1;
      seen_fall_q <= 1'b0;
      gap_q       <= '0;
    end else begin
      prev_clk_q <= conv_clk_o;
      if (fell) begin
        seen_fall_q <= 1'b1;
        gap_q       <= GAP_W'(1);
      end else if (gap_q != {GAP_W{1'b1}}) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  initial begin
    AST_WORD_FITS: assert (NUM_SWEEPS * (2 ** SAMPLE_W - 1) < 2 ** DATA_W); // R9
  end

  AST_CONV_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fell |-> !trig_out_o); // R2

  AST_CONV_PACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fell && seen_fall_q |-> gap_q >= GAP_W'(CONV_PERIOD)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr |-> mem_wdata_o >= rd_data); // R9

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> conv_clk_o && !trig_out_o && !mem_we_o); // R6

  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o && !trig_out_o && conv_clk_o && !mem_we_o); // R8

  AST_CHAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_clk_o |-> $stable(chan_sel_o)); // R7
endmodule

bind acq_integrator acq_integrator_chk #(
  .SAMPLE_W   (SAMPLE_W),
  .DATA_W     (DATA_W),
  .NUM_SWEEPS (NUM_SWEEPS),
  .CONV_PERIOD(CONV_PERIOD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_out_o  (trig_out_o),
  .conv_clk_o  (conv_clk_o),
  .chan_sel_o  (chan_sel_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .acc_wr      (acc_wr),
  .rd_data     (rd_data)
);

// File: tb/acq_integrator_tb_top.sv
module acq_integrator_tb_top;
  localparam int DEPTH   = 8;
  localparam int NSWP    = 3;
  localparam int PERIOD  = 10;
  localparam int LOW     = 2;
  localparam int TMO_W   = 8;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int TOTAL_W = DEPTH * (1 + NSWP);

  // {chan[31:30], mode[29:28], seed[27:16], expected word 0 [15:0]}
  // mode 0: sample k = seed + 97*k, mode 1: all ones, mode 2: zero
  localparam logic [31:0] VEC [4] = '{
    {2'd0, 2'd0, 12'd5,    16'h0927},
    {2'd1, 2'd1, 12'd0,    16'h2FFD},
    {2'd2, 2'd0, 12'd3000, 16'h1C40},
    {2'd3, 2'd2, 12'd0,    16'h0000}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        chan = '0;
  logic [TMO_W-1:0]  tmo = '0;
  logic              trig_out, trig_in = 1'b0;
  logic              conv_clk;
  logic [1:0]        chan_sel;
  logic [11:0]       adc_data = '0;
  logic              adc_eoc = 1'b0;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       wdata;
  logic              done, err;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, acc_cnt = 0, conv_cnt = 0;
  int gap = 0, low_len = 0;
  bit seen_fall = 0, prev_conv = 1, trig_en = 1;
  logic [1:0]  cur_mode = '0, exp_chan = '0;
  logic [11:0] cur_seed = '0;
  logic [15:0] model [DEPTH];

  always #2 clk = ~clk;

  acq_integrator #(
    .DEPTH(DEPTH), .SAMPLE_W(12), .DATA_W(16), .NUM_SWEEPS(NSWP),
    .CONV_PERIOD(PERIOD), .CONV_LOW(LOW), .SYNC_STAGES(2), .TMO_W(TMO_W)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan),
    .timeout_i(tmo), .trig_out_o(trig_out), .trig_in_i(trig_in),
    .conv_clk_o(conv_clk), .chan_sel_o(chan_sel), .adc_data_i(adc_data),
    .adc_eoc_i(adc_eoc), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] smp_of(input int k);
    case (cur_mode)
      2'd0:    return 12'(int'(cur_seed) + k * 97);
      2'd1:    return 12'hFFF;
      default: return 12'h000;
    endcase
  endfunction

  // converter model: falling edge starts, eoc rises with the result
  initial begin
    forever begin
      logic [11:0] s;
      @(negedge conv_clk);
      s = smp_of(conv_cnt);
      conv_cnt++;
      @(negedge clk) adc_eoc = 1'b0;
      repeat (3) @(negedge clk);
      adc_data = s;
      @(negedge clk) adc_eoc = 1'b1;
    end
  end

  // signal generator model: acknowledge two cycles after the request
  initial begin
    forever begin
      @(negedge clk);
      if (trig_en && trig_out && !trig_in) begin
        repeat (2) @(negedge clk);
        trig_in = 1'b1;
      end else if (!trig_out) begin
        trig_in = 1'b0;
      end
    end
  end

  // write and conversion-clock monitor
  always @(negedge clk) begin
    if (rst_n && we) begin
      if (wr_cnt < DEPTH) begin
        chk(int'(addr) == wr_cnt, "R1", "clear address", int'(addr), wr_cnt);
        chk(wdata == 16'h0, "R1", "clear data", int'(wdata), 0);
        model[addr] = 16'h0;
      end else begin
        logic [15:0] e;
        e = model[acc_cnt % DEPTH] + 16'(smp_of(acc_cnt));
        chk(int'(addr) == acc_cnt % DEPTH, "R5", "sample index",
            int'(addr), acc_cnt % DEPTH);
        chk(wdata == e, "R4", "accumulated word", int'(wdata), int'(e));
        model[addr] = wdata;
        acc_cnt++;
      end
      wr_cnt++;
    end
    if (rst_n) begin
      if (prev_conv && !conv_clk) begin
        if (seen_fall) chk(gap >= PERIOD, "R3", "fall spacing", gap, PERIOD);
        chk(!trig_out, "R2", "conversion while trigger pending", int'(trig_out), 0);
        chk(chan_sel == exp_chan, "R7", "select during run", int'(chan_sel), int'(exp_chan));
        seen_fall = 1;
        gap = 1;
        low_len = 1;
      end else begin
        gap++;
        if (!conv_clk) low_len++;
        if (!prev_conv && conv_clk) chk(low_len == LOW, "R3", "low width", low_len, LOW);
      end
      prev_conv = conv_clk;
    end
  end

  task automatic begin_run(input logic [1:0] c, input logic [1:0] m, input logic [11:0] sd);
    @(negedge clk);
    cur_mode = m;
    cur_seed = sd;
    exp_chan = c;
    chan     = c;
    wr_cnt   = 0;
    acc_cnt  = 0;
    conv_cnt = 0;
    start    = 1'b1;
    @(negedge clk) start = 1'b0;
    chan = ~c;
  endtask

  task automatic wait_done(input bit poke);
    bit poked = 0;
    while (!done) begin
      @(negedge clk);
      if (poke && !poked && acc_cnt == 5) begin
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        poked = 1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(trig_out == 1'b0, "R10", "reset trig_out", int'(trig_out), 0);
    chk(conv_clk == 1'b1, "R10", "reset conv_clk", int'(conv_clk), 1);
    chk(done == 1'b0, "R10", "reset done", int'(done), 0);
    chk(err == 1'b0, "R10", "reset err", int'(err), 0);
    chk(we == 1'b0, "R10", "reset write", int'(we), 0);
    rst_n = 1'b1;

    // R8: acknowledge never comes, timeout of 20 cycles
    trig_en = 0;
    tmo = 8'd20;
    begin_run(2'd1, 2'd0, 12'd1);
    while (!trig_out) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(err == 1'b0, "R8", "err before timeout", int'(err), 0);
    chk(trig_out == 1'b1, "R8", "trig held before timeout", int'(trig_out), 1);
    repeat (20) @(negedge clk);
    chk(err == 1'b1, "R8", "err after timeout", int'(err), 1);
    chk(trig_out == 1'b0, "R8", "trig dropped after timeout", int'(trig_out), 0);
    chk(done == 1'b0, "R8", "no done on timeout", int'(done), 0);
    repeat (30) @(negedge clk);
    chk(wr_cnt == DEPTH, "R8", "writes after abort", wr_cnt, DEPTH);
    chk(conv_cnt == 0, "R8", "conversions after abort", conv_cnt, 0);
    trig_en = 1;

    // table of full runs
    for (int v = 0; v < 4; v++) begin
      tmo = (v % 2 == 0) ? 8'd0 : 8'd30;
      begin_run(VEC[v][31:30], VEC[v][29:28], VEC[v][27:16]);
      repeat (2) @(negedge clk);
      chk(err == 1'b0, "R8", "err cleared by start", int'(err), 0);
      chk(done == 1'b0, "R6", "done cleared by start", int'(done), 0);
      wait_done(v == 1);
      @(negedge clk);
      chk(wr_cnt == TOTAL_W, "R5", "writes per run", wr_cnt, TOTAL_W);
      chk(model[0] == VEC[v][15:0], "R9", "final word 0", int'(model[0]), int'(VEC[v][15:0]));
      chk(chan_sel == VEC[v][31:30], "R7", "select after run", int'(chan_sel), int'(VEC[v][31:30]));
      chk(err == 1'b0, "R8", "no err on good run", int'(err), 0);
      repeat (5) @(negedge clk);
      chk(done == 1'b1, "R6", "done held", int'(done), 1);
      chk(trig_out == 1'b0 && conv_clk == 1'b1, "R6", "idle outputs after done",
          int'({trig_out, conv_clk}), 1);
    end

    // R8: timeout of zero waits without limit
    trig_en = 0;
    tmo = 8'd0;
    begin_run(2'd2, 2'd1, 12'd0);
    while (!trig_out) @(negedge clk);
    repeat (100) @(negedge clk);
    chk(err == 1'b0, "R8", "no timeout when zero", int'(err), 0);
    chk(trig_out == 1'b1, "R2", "trig held awaiting ack", int'(trig_out), 1);
    chk(conv_cnt == 0, "R2", "no conversion before ack", conv_cnt, 0);
    trig_en = 1;
    wait_done(0);
    @(negedge clk);
    chk(model[DEPTH-1] == 16'h2FFD, "R9", "full-scale sum", int'(model[DEPTH-1]), 16'h2FFD);
    chk(wr_cnt == TOTAL_W, "R5", "writes after late ack", wr_cnt, TOTAL_W);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule